// File: doc/BRIEF.md
# Flow-Through Synchronous Burst RAM

This block is a synthesizable behavioural model of a small synchronous burst RAM whose read path has no output register. Every control and data input is captured on the rising clock edge. A load cycle takes a new external address and samples three chip enables. Later cycles either stall on that address or step a two-bit burst counter through the low address bits. Each word holds four data bytes, and each byte has its own parity bit. A write can cover the whole word or only selected byte lanes, with each lane's parity bit included.

Read data flows from the registered address straight to the output in the same cycle. The output has no valid/ready handshake and applies no back-pressure. `rvalid_o` marks the cycles in which `rdata_o` is being driven, and a consumer must take the word in that cycle. An asynchronous output enable and an asynchronous sleep input both gate the output. Sleep also freezes all internal state.

Top module: `fts_burst_ram`

## Requirements
- R1: While reset is asserted and after it is released, the device is deselected: `rvalid_o` is low and `rdata_o` is zero until a selected load occurs.
- R2: A load happens on an edge where `ld_n_i` and `sel_a_n_i` are both low. It captures `addr_i` and ignores all write controls on that edge. A low `ld_n_i` while `sel_a_n_i` is high is not a load.
- R3: The device becomes selected only if a load edge sees `sel_a_n_i`=0, `sel_b_n_i`=0 and `sel_c_i`=1. On any edge that is not a load, the chip enables have no effect.
- R4: When `wall_n_i` is low on a non-load edge, all 36 bits of `wdata_i` are written, whatever `lane_wr_n_i` and `lane_en_n_i` are.
- R5: When `wall_n_i` is high and `lane_wr_n_i` is low, each lane k with `lane_en_n_i[k]`=0 writes data bits [8k+7:8k] and parity bit 32+k. The other lanes keep their contents.
- R6: An edge with no write qualifier active is a read cycle and leaves the array unchanged. This includes `lane_wr_n_i` low with all four lane enables high.
- R7: On a non-load edge with `step_n_i` low, address bits [1:0] advance in the order 00,01,10,11,00 and the upper bits stay fixed. A write on that edge goes to the advanced address.
- R8: On a non-load edge with `step_n_i` high, the address is held (wait state).
- R9: On the first edge after a load, `step_n_i` must be high, so that a write on that edge lands on the loaded address. Breaking this rule is flagged by an assertion.
- R10: `rdata_o` shows the word at the registered address in the same cycle, with no output register. A write becomes visible in the cycle after its edge.
- R11: While `sleep_i` is high, edges ignore every input, the address, the selection and the array are kept, and `rvalid_o` is low at once.
- R12: `drive_en_n_i` high forces `rvalid_o` low and `rdata_o` to zero at once, and it leaves all state untouched.
- R13: While the device is deselected, writes are ignored and `rvalid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Asynchronous sleep: freezes state and gates output |
| addr_i | input | ADDR_W | External address captured on load |
| wdata_i | input | 36 | Write word: bytes at [31:0], parity for lane k at bit 32+k |
| ld_n_i | input | 1 | Address load strobe, active low |
| sel_a_n_i | input | 1 | Primary chip enable, active low, also qualifies the strobe |
| sel_b_n_i | input | 1 | Second chip enable, active low |
| sel_c_i | input | 1 | Third chip enable, active high |
| step_n_i | input | 1 | Burst advance, active low |
| wall_n_i | input | 1 | Whole-word write, active low |
| lane_wr_n_i | input | 1 | Lane-write enable, active low |
| lane_en_n_i | input | 4 | Per-lane write enables, active low |
| drive_en_n_i | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | 36 | Flow-through read word, zero when not driven |
| rvalid_o | output | 1 | High while the read word is driven |

## Verification
On every cycle, the assertions check the address sequencer: stalls hold the address, advances wrap the low two bits with the upper bits fixed, sleep freezes the address and selection, the selection changes only on a load, and the step rule after a load is kept. Only the bench's scenarios can show the data-path results. These are the lane-by-lane merging of partial writes with their parity bits, a whole-word write overriding the lane controls, writes ignored while deselected or asleep, and the same-cycle visibility of stored words at the output.

// File: rtl/fts_pkg.sv
package fts_pkg;
  // kind of write selected by the three-level decode
  typedef enum logic [1:0] {
    WK_NONE  = 2'd0,
    WK_LANES = 2'd1,
    WK_FULL  = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/fts_addr_seq.sv
module fts_addr_seq #(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              load,
  input  logic              sel_in,
  input  logic              step_n,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              sel_q,
  output logic              first_q
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic [BURST_W-1:0] lo_next;

  always_comb begin
    lo_next  = cur_addr[BURST_W-1:0];
    if (!step_n) lo_next = cur_addr[BURST_W-1:0] + 1'b1;
    eff_addr = {cur_addr[ADDR_W-1:BURST_W], lo_next};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      sel_q    <= 1'b0;
      first_q  <= 1'b0;
    end else if (!hold) begin
      if (load) begin
        cur_addr <= addr_i;
        sel_q    <= sel_in;
        first_q  <= 1'b1;
      end else begin
        cur_addr <= eff_addr;
        first_q  <= 1'b0;
      end
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !load && step_n) |=> (cur_addr == $past(cur_addr)));

  // R7
  wrap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !load && !step_n) |=>
      ((cur_addr[BURST_W-1:0] == BURST_W'($past(cur_addr[BURST_W-1:0]) + 1'b1)) &&
       (cur_addr[ADDR_W-1:BURST_W] == $past(cur_addr[ADDR_W-1:BURST_W]))));

  // R11
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(cur_addr) && $stable(sel_q)));

  // R3
  sel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !load) |=> $stable(sel_q));

  // R9
  first_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first_q && !hold && !load) |-> step_n);

  if (HI_W < 1) begin : g_bad_width
    initial $display("fts_addr_seq: ADDR_W must exceed BURST_W");
  end
endmodule

// File: rtl/fts_wr_decode.sv
module fts_wr_decode
  import fts_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             wall_n,
  input  logic             lane_wr_n,
  input  logic [LANES-1:0] lane_en_n,
  output logic [LANES-1:0] mask
);
  wr_kind_e kind;

  // whole-word write wins, then the lane-write enable, else read
  always_comb begin
    if (!wall_n)         kind = WK_FULL;
    else if (!lane_wr_n) kind = WK_LANES;
    else                 kind = WK_NONE;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_mask
    assign mask[k] = (kind == WK_FULL) || ((kind == WK_LANES) && !lane_en_n[k]);
  end
endmodule

// File: rtl/fts_store.sv
module fts_store #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int WORD_W = LANES * (LANE_W + 1),
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int PAR_LO = LANES * LANE_W
) (
  input  logic              clk,
  input  logic [LANES-1:0]  we_mask,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  // one narrow array per lane: data byte with its parity bit on top
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W:0] cells [DEPTH];
    logic [LANE_W:0] lane_rd;

    always_ff @(posedge clk) begin
      if (we_mask[k]) cells[waddr] <= {wdata[PAR_LO + k], wdata[k*LANE_W +: LANE_W]};
    end

    assign lane_rd                      = cells[raddr];
    assign rdata[k*LANE_W +: LANE_W]    = lane_rd[LANE_W-1:0];
    assign rdata[PAR_LO + k]            = lane_rd[LANE_W];
  end
endmodule

// File: rtl/fts_burst_ram.sv
module fts_burst_ram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int WORD_W = LANES * (LANE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              ld_n_i,
  input  logic              sel_a_n_i,
  input  logic              sel_b_n_i,
  input  logic              sel_c_i,
  input  logic              step_n_i,
  input  logic              wall_n_i,
  input  logic              lane_wr_n_i,
  input  logic [LANES-1:0]  lane_en_n_i,
  input  logic              drive_en_n_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rvalid_o
);
  localparam int BURST_W = 2;

  logic              load;
  logic              sel_in;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] eff_addr;
  logic              sel_q;
  logic              first_q;
  logic [LANES-1:0]  lane_mask;
  logic [LANES-1:0]  we_mask;
  logic [WORD_W-1:0] rd_word;

  // strobe counts only when the primary enable is low
  assign load   = !ld_n_i && !sel_a_n_i;
  assign sel_in = !sel_a_n_i && !sel_b_n_i && sel_c_i;

  fts_addr_seq #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (sleep_i),
    .load     (load),
    .sel_in   (sel_in),
    .step_n   (step_n_i),
    .addr_i   (addr_i),
    .cur_addr (cur_addr),
    .eff_addr (eff_addr),
    .sel_q    (sel_q),
    .first_q  (first_q)
  );

  fts_wr_decode #(.LANES(LANES)) u_dec (
    .wall_n    (wall_n_i),
    .lane_wr_n (lane_wr_n_i),
    .lane_en_n (lane_en_n_i),
    .mask      (lane_mask)
  );

  // writes only when awake, selected and not on a load edge
  assign we_mask = (!sleep_i && !load && sel_q) ? lane_mask : '0;

  fts_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk     (clk),
    .we_mask (we_mask),
    .waddr   (eff_addr),
    .wdata   (wdata_i),
    .raddr   (cur_addr),
    .rdata   (rd_word)
  );

  assign rvalid_o = sel_q && !drive_en_n_i && !sleep_i;
  assign rdata_o  = rvalid_o ? rd_word : '0;
endmodule

// File: tb/fts_burst_ram_bench.sv
module fts_burst_ram_bench;
  localparam int AW = 8;
  localparam int WW = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sleep_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [WW-1:0] wdata_i = '0;
  logic          ld_n_i = 1'b1, sel_a_n_i = 1'b1, sel_b_n_i = 1'b1, sel_c_i = 1'b0;
  logic          step_n_i = 1'b1, wall_n_i = 1'b1, lane_wr_n_i = 1'b1;
  logic [3:0]    lane_en_n_i = 4'hF;
  logic          drive_en_n_i = 1'b0;
  logic [WW-1:0] rdata_o;
  logic          rvalid_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [WW-1:0] m_mem [256];
  logic [3:0]    m_kn  [256];
  logic [AW-1:0] m_addr = '0;
  bit            m_sel = 0;
  bit            m_first = 0;

  always #5 clk = ~clk;

  fts_burst_ram u_fts_burst_ram (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .ld_n_i(ld_n_i), .sel_a_n_i(sel_a_n_i), .sel_b_n_i(sel_b_n_i), .sel_c_i(sel_c_i),
    .step_n_i(step_n_i), .wall_n_i(wall_n_i), .lane_wr_n_i(lane_wr_n_i),
    .lane_en_n_i(lane_en_n_i), .drive_en_n_i(drive_en_n_i),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  function automatic logic [3:0] exp_mask();
    if (!wall_n_i) return 4'hF;
    if (!lane_wr_n_i) return ~lane_en_n_i;
    return 4'h0;
  endfunction

  // reference update at a clock edge, from the requirements
  task automatic model_edge();
    logic [AW-1:0] a;
    logic [3:0] mk;
    if (sleep_i) return;
    if (!ld_n_i && !sel_a_n_i) begin
      m_addr  = addr_i;
      m_sel   = !sel_b_n_i && sel_c_i;
      m_first = 1;
    end else begin
      a = step_n_i ? m_addr : {m_addr[AW-1:2], m_addr[1:0] + 2'd1};
      mk = exp_mask();
      if (m_sel) begin
        for (int k = 0; k < 4; k++) begin
          if (mk[k]) begin
            m_mem[a][8*k +: 8] = wdata_i[8*k +: 8];
            m_mem[a][32+k]     = wdata_i[32+k];
            m_kn[a][k]         = 1'b1;
          end
        end
      end
      m_addr  = a;
      m_first = 0;
    end
  endtask

  task automatic check(input string tag);
    bit ev;
    ev = m_sel && !drive_en_n_i && !sleep_i;
    checks++;
    if (rvalid_o !== ev) begin
      errors++;
      $display("FAIL %s: rvalid=%0b expected %0b", tag, rvalid_o, ev);
    end
    if (ev && m_kn[m_addr] == 4'hF) begin
      checks++;
      if (rdata_o !== m_mem[m_addr]) begin
        errors++;
        $display("FAIL %s: rdata=%h expected %h (addr %h)", tag, rdata_o, m_mem[m_addr], m_addr);
      end
    end else if (!ev) begin
      checks++;
      if (rdata_o !== '0) begin
        errors++;
        $display("FAIL %s: rdata=%h expected 0 when not driven", tag, rdata_o);
      end
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_edge();
    #1;
    check(tag);
  endtask

  task automatic idle();
    ld_n_i = 1'b1; sel_a_n_i = 1'b1; sel_b_n_i = 1'b1; sel_c_i = 1'b0;
    step_n_i = 1'b1; wall_n_i = 1'b1; lane_wr_n_i = 1'b1; lane_en_n_i = 4'hF;
    sleep_i = 1'b0; drive_en_n_i = 1'b0;
  endtask

  task automatic do_load(input logic [AW-1:0] a, input bit on, input string tag);
    idle();
    ld_n_i = 1'b0; sel_a_n_i = 1'b0; sel_b_n_i = !on; sel_c_i = 1'b1;
    addr_i = a;
    wall_n_i = 1'b0; wdata_i = 36'hBAD_BAD_BAD; // ignored on a load edge
    tick(tag);
  endtask

  task automatic do_full(input logic [WW-1:0] d, input bit step, input string tag);
    idle();
    wall_n_i = 1'b0; lane_wr_n_i = 1'b0; lane_en_n_i = 4'b1010; // lane controls overridden
    step_n_i = !step; wdata_i = d;
    tick(tag);
  endtask

  task automatic do_lanes(input logic [WW-1:0] d, input logic [3:0] en_n, input bit step,
                          input string tag);
    idle();
    lane_wr_n_i = 1'b0; lane_en_n_i = en_n; step_n_i = !step; wdata_i = d;
    tick(tag);
  endtask

  task automatic do_read(input bit step, input string tag);
    idle();
    step_n_i = !step;
    tick(tag);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin m_mem[i] = '0; m_kn[i] = 4'h0; end
    void'($urandom(32'd4711));
    idle();
    repeat (3) @(posedge clk);
    #1 check("R1 in reset");
    rst_n = 1'b1;
    do_read(1'b0, "R1 after reset");
    do_full(36'h1_2345_6789, 1'b0, "R13 write before any load");

    // R9 / R4: load, hold step high, whole-word write lands on loaded address
    do_load(8'h13, 1'b1, "R2 load");
    do_full(36'hA_DEAD_BEEF, 1'b0, "R9 write on first edge");
    do_read(1'b0, "R4 whole word");
    do_lanes(36'h5_1122_3344, 4'b1010, 1'b0, "R5 lanes 0 and 2");
    do_read(1'b0, "R5 merged word");
    do_lanes(36'hF_FFFF_FFFF, 4'hF, 1'b0, "R6 no lane enabled");
    do_read(1'b0, "R10 same-cycle read");

    // R7 burst writes and wrap
    do_load(8'h10, 1'b1, "R2 load burst");
    do_full(36'h0_0000_0010, 1'b0, "R7 write 10");
    do_full(36'h1_0000_0011, 1'b1, "R7 write 11");
    do_full(36'h2_0000_0012, 1'b1, "R7 write 12");
    do_full(36'h3_0000_0013, 1'b1, "R7 write 13");
    do_read(1'b1, "R7 wrap to 10");
    do_read(1'b0, "R8 stall");
    do_read(1'b0, "R8 stall again");

    // R3: enables ignored after load
    idle(); sel_b_n_i = 1'b1; sel_c_i = 1'b0; wall_n_i = 1'b0; wdata_i = 36'h7_7777_7777;
    tick("R3 write with enables dropped");
    do_read(1'b0, "R3 still selected");

    // R2: strobe without primary enable is not a load
    idle(); ld_n_i = 1'b0; addr_i = 8'h40; tick("R2 unqualified strobe");

    // R13: deselected load, write ignored, reselect
    do_load(8'h11, 1'b0, "R13 deselected load");
    do_full(36'h9_9999_9999, 1'b0, "R13 write ignored");
    do_load(8'h11, 1'b1, "R13 reselect");
    do_read(1'b0, "R13 old data kept");

    // R11 sleep
    idle(); sleep_i = 1'b1; ld_n_i = 1'b0; sel_a_n_i = 1'b0; sel_b_n_i = 1'b1; addr_i = 8'h55;
    tick("R11 load while asleep");
    idle(); sleep_i = 1'b1; wall_n_i = 1'b0; step_n_i = 1'b0; wdata_i = 36'h0;
    tick("R11 write while asleep");
    do_read(1'b0, "R11 state kept");

    // R12 output enable
    idle(); drive_en_n_i = 1'b1; tick("R12 output off");
    do_read(1'b0, "R12 output back");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = $urandom_range(0, 19);
      idle();
      sel_a_n_i = 1'($urandom);
      sel_b_n_i = 1'($urandom);
      sel_c_i   = 1'($urandom);
      ld_n_i    = sel_a_n_i ? 1'($urandom) : 1'b1;
      step_n_i  = m_first ? 1'b1 : 1'($urandom);
      wdata_i   = {4'($urandom), 32'($urandom)};
      addr_i    = {6'($urandom_range(0, 3)), 2'($urandom)};
      lane_en_n_i = 4'($urandom);
      drive_en_n_i = ($urandom_range(0, 9) == 0);
      if (op < 3) begin
        ld_n_i = 1'b0; sel_a_n_i = 1'b0; sel_b_n_i = ($urandom_range(0, 4) == 0); sel_c_i = 1'b1;
        wall_n_i = 1'($urandom);
        tick("R2 random load");
      end else if (op < 8) begin
        wall_n_i = 1'b0; lane_wr_n_i = 1'($urandom);
        tick("R4 random whole write");
      end else if (op < 13) begin
        lane_wr_n_i = 1'b0;
        tick("R5 random lane write");
      end else if (op < 18) begin
        tick("R7 random read");
      end else begin
        sleep_i = 1'b1; wall_n_i = 1'($urandom); ld_n_i = 1'($urandom); sel_a_n_i = 1'($urandom);
        tick("R11 random sleep");
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule